// File: doc/BRIEF.md
# Configurable Four-Input Logic Cell

This block is a single programmable logic cell of the kind tiled by the thousand across a reconfigurable fabric. A 16-bit configuration mask turns a four-input lookup table into any Boolean function of its inputs. An arithmetic mode turns the same cell into one bit of a ripple adder. In that mode a run-time add/subtract control decides, cycle by cycle, whether the cell adds or subtracts.

The cell holds one storage bit, with several ways to change it:
- asynchronous clear, which forces 0;
- asynchronous load, which acts as a preset when the load value is 1;
- a synchronous reset;
- enable-gated synchronous clear and synchronous load;
- normal capture of either the cell's own result or a neighbour's register value arriving over a register chain.

The cell picks one of the cluster's clocks together with that clock's own enable. A configuration bit chooses whether the main output shows the stored value or the combinational value. The lookup-table result is also offered to the adjacent cell over a direct chain output.

Top module: `cfg_logic_cell`

## Requirements
- R1: With `cfg_arith`=0, `comb_out` equals bit `{din[3],din[2],din[1],din[0]}` of `cfg_lut`, where din[0] is the least significant index bit, and `carry_out` is 0.
- R2: `lut_chain_out` always equals `comb_out`.
- R3: With `cfg_arith`=1, `{carry_out, comb_out}` equals the two-bit sum A + B' + Cin, where A=din[0], B'=din[1] when `add_sub`=0 and B'=~din[1] when `add_sub`=1.
- R4: Cin is `add_sub` itself when `cfg_first`=1 (0 to add, 1 to subtract), and `carry_in` when `cfg_first`=0.
- R5: `aclr`=1 forces `reg_out` to 0 at once and overrides `aload`. `aload`=1 with `aclr`=0 makes `reg_out` follow `ld_data` at once, so it acts as a preset when `ld_data`=1. After `aload` drops, the last value loaded is kept.
- R6: `rst`=1 clears the register at a clock edge whatever the enable.
- R7: With the selected enable low, the register keeps its value at a clock edge even if `sclr`, `sload` or the data change.
- R8: With the selected enable high, `sclr` wins over `sload`, and `sload` (capturing `ld_data`) wins over normal data.
- R9: Normal data is `comb_out` when `cfg_chain_src`=0 and `reg_chain_in` when it is 1. `reg_chain_out` equals `reg_out`.
- R10: `cfg_clk_sel` selects the clock from `clk_bus` and, with it, the enable bit of the same index in `ena_bus`.
- R11: `cell_out` equals `reg_out` when `cfg_out_reg`=1 and `comb_out` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | N_CLK | Cluster clocks |
| ena_bus | input | N_CLK | Clock enables, one linked to each clock |
| rst | input | 1 | Synchronous active-high reset of the register |
| aclr | input | 1 | Asynchronous clear |
| aload | input | 1 | Asynchronous load |
| ld_data | input | 1 | Value for asynchronous and synchronous load |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load |
| add_sub | input | 1 | 0 add, 1 subtract (arithmetic mode) |
| din | input | N_IN | Lookup-table inputs; din[0]/din[1] are the arithmetic operands |
| carry_in | input | 1 | Carry from the lower-order cell |
| reg_chain_in | input | 1 | Register value of the neighbouring cell |
| cfg_lut | input | 2**N_IN | Lookup-table mask |
| cfg_arith | input | 1 | Arithmetic mode |
| cfg_first | input | 1 | Cell is the least significant bit of its chain |
| cfg_chain_src | input | 1 | Register data from the register chain |
| cfg_clk_sel | input | $clog2(N_CLK) | Clock/enable pair select |
| cfg_out_reg | input | 1 | Main output shows the register |
| comb_out | output | 1 | Combinational result |
| reg_out | output | 1 | Registered result |
| cell_out | output | 1 | Selected main output |
| carry_out | output | 1 | Carry to the next cell |
| lut_chain_out | output | 1 | Combinational result to the adjacent cell |
| reg_chain_out | output | 1 | Register value to the adjacent cell |

## Verification
The hardest state to reach is the overlap of the two asynchronous controls. Load is raised first, then clear is asserted on top of it and held across clock edges. The bench then drops clear while load is still high, and only later drops load. This shows the override, the return to the load value, and the value kept once both are low. The enable-gating cases are built in a similar way. The selected enable is held low, or the other clock's enable is raised instead, and in that state the bench presents clear, load and fresh data so that any capture would show on `reg_out`. The lookup table is swept over every index for all sixteen one-hot masks plus a parity mask. The arithmetic path is swept over all 32 combinations of its operands and controls.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic {SRC_LOCAL = 1'b0, SRC_CHAIN = 1'b1} reg_src_e;
endpackage

// File: rtl/lc_lut.sv
module lc_lut #(
  parameter int N_IN = 4,
  localparam int SIZE = 1 << N_IN
) (
  input  logic [SIZE-1:0] mask,
  input  logic [N_IN-1:0] idx,
  output logic            y
);
  for (genvar l = 0; l < N_IN; l++) begin : g_lvl
    localparam int W = SIZE >> (l + 1);
    logic [W-1:0] node;
    for (genvar n = 0; n < W; n++) begin : g_node
      if (l == 0) begin : g_leaf
        assign node[n] = idx[0] ? mask[2*n+1] : mask[2*n];
      end else begin : g_inner
        assign node[n] = idx[l] ? g_lvl[l-1].node[2*n+1] : g_lvl[l-1].node[2*n];
      end
    end
  end
  assign y = g_lvl[N_IN-1].node[0];
endmodule

// File: rtl/lc_arith.sv
module lc_arith (
  input  logic a,
  input  logic b,
  input  logic sub,
  input  logic cin,
  output logic sum,
  output logic cout
);
  logic bx;
  assign bx   = b ^ sub;
  assign sum  = a ^ bx ^ cin;
  assign cout = (a & bx) | (a & cin) | (bx & cin);

  always_comb begin
    AST_ARITH_SUM: assert ({cout, sum} == (2'(a) + 2'(bx) + 2'(cin))) else $error("arith mismatch"); // R3
  end
endmodule

// File: rtl/lc_reg.sv
module lc_reg (
  input  logic clk,
  input  logic rst,
  input  logic ena,
  input  logic aclr,
  input  logic aload,
  input  logic ld_data,
  input  logic sclr,
  input  logic sload,
  input  logic d,
  output logic q
);
  logic core;

  always_ff @(posedge clk or posedge aclr or posedge aload) begin
    if (aclr)        core <= 1'b0;
    else if (aload)  core <= ld_data;
    else if (rst)    core <= 1'b0;
    else if (ena) begin
      if (sclr)       core <= 1'b0;
      else if (sload) core <= ld_data;
      else            core <= d;
    end
  end

  assign q = aclr ? 1'b0 : (aload ? ld_data : core);

  AST_ACLR_ZERO: assert property (@(posedge clk) disable iff (rst) aclr |-> !core); // R5
  AST_ALOAD_VAL: assert property (@(posedge clk) disable iff (rst)
    (aload && !aclr && $stable(aclr) && $stable(ld_data)) |-> core == ld_data); // R5
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!ena && !aclr && !aload) |=> (aclr || aload || rst || core == $past(core))); // R7
  AST_SCLR_WIN: assert property (@(posedge clk) disable iff (rst)
    (ena && sclr && !aclr && !aload) |=> (aclr || aload || !core)); // R8
  AST_SLOAD_VAL: assert property (@(posedge clk) disable iff (rst)
    (ena && !sclr && sload && !aclr && !aload) |=> (aclr || aload || core == $past(ld_data))); // R8
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell #(
  parameter int N_IN  = 4,
  parameter int N_CLK = 2,
  localparam int LUT_SIZE = 1 << N_IN,
  localparam int SEL_W    = $clog2(N_CLK)
) (
  input  logic [N_CLK-1:0]    clk_bus,
  input  logic [N_CLK-1:0]    ena_bus,
  input  logic                rst,
  input  logic                aclr,
  input  logic                aload,
  input  logic                ld_data,
  input  logic                sclr,
  input  logic                sload,
  input  logic                add_sub,
  input  logic [N_IN-1:0]     din,
  input  logic                carry_in,
  input  logic                reg_chain_in,
  input  logic [LUT_SIZE-1:0] cfg_lut,
  input  logic                cfg_arith,
  input  logic                cfg_first,
  input  logic                cfg_chain_src,
  input  logic [SEL_W-1:0]    cfg_clk_sel,
  input  logic                cfg_out_reg,
  output logic                comb_out,
  output logic                reg_out,
  output logic                cell_out,
  output logic                carry_out,
  output logic                lut_chain_out,
  output logic                reg_chain_out
);
  import lc_pkg::*;

  logic lut_y, sum, cout, cin_eff, cell_clk, cell_ena, d_next, q;
  reg_src_e src;

  lc_lut #(.N_IN(N_IN)) lut_i (.mask(cfg_lut), .idx(din), .y(lut_y));

  assign cin_eff = cfg_first ? add_sub : carry_in;

  lc_arith arith_i (
    .a(din[0]), .b(din[1]), .sub(add_sub), .cin(cin_eff),
    .sum(sum), .cout(cout)
  );

  assign comb_out      = cfg_arith ? sum : lut_y;
  assign carry_out     = cfg_arith & cout;
  assign lut_chain_out = comb_out;

  assign cell_clk = clk_bus[cfg_clk_sel];
  assign cell_ena = ena_bus[cfg_clk_sel];
  assign src      = reg_src_e'(cfg_chain_src);
  assign d_next   = (src == SRC_CHAIN) ? reg_chain_in : comb_out;

  lc_reg reg_i (
    .clk(cell_clk), .rst(rst), .ena(cell_ena), .aclr(aclr), .aload(aload),
    .ld_data(ld_data), .sclr(sclr), .sload(sload), .d(d_next), .q(q)
  );

  assign reg_out       = q;
  assign reg_chain_out = q;
  assign cell_out      = cfg_out_reg ? q : comb_out;

  AST_CHAIN_CAPTURE: assert property (@(posedge cell_clk) disable iff (rst)
    (cell_ena && cfg_chain_src && !sclr && !sload && !aclr && !aload && $stable(cfg_chain_src))
    |=> (aclr || aload || reg_chain_out == $past(reg_chain_in))); // R9
endmodule

// File: tb/cfg_logic_cell_tb_top.sv
module cfg_logic_cell_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]  clk_bus, ena_bus;
  logic        rst, aclr, aload, ld_data, sclr, sload, add_sub, carry_in, reg_chain_in;
  logic [3:0]  din;
  logic [15:0] cfg_lut;
  logic        cfg_arith, cfg_first, cfg_chain_src, cfg_out_reg;
  logic [0:0]  cfg_clk_sel;
  logic        comb_out, reg_out, cell_out, carry_out, lut_chain_out, reg_chain_out;
  int nvec = 0, nfail = 0;

  assign clk_bus = {clk, clk};

  cfg_logic_cell dut_i (
    .clk_bus(clk_bus), .ena_bus(ena_bus), .rst(rst), .aclr(aclr), .aload(aload),
    .ld_data(ld_data), .sclr(sclr), .sload(sload), .add_sub(add_sub), .din(din),
    .carry_in(carry_in), .reg_chain_in(reg_chain_in), .cfg_lut(cfg_lut),
    .cfg_arith(cfg_arith), .cfg_first(cfg_first), .cfg_chain_src(cfg_chain_src),
    .cfg_clk_sel(cfg_clk_sel), .cfg_out_reg(cfg_out_reg), .comb_out(comb_out),
    .reg_out(reg_out), .cell_out(cell_out), .carry_out(carry_out),
    .lut_chain_out(lut_chain_out), .reg_chain_out(reg_chain_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst = 1; aclr = 0; aload = 0; ld_data = 0; sclr = 0; sload = 0; add_sub = 0;
    carry_in = 0; reg_chain_in = 0; din = 0; cfg_lut = 16'hAAAA; cfg_arith = 0;
    cfg_first = 0; cfg_chain_src = 0; cfg_clk_sel = 0; cfg_out_reg = 0; ena_bus = 2'b00;
    tick(); tick();
    chk("R6 reset state", reg_out, 1'b0);
    rst = 0;

    // R1 R2 R11: one-hot masks over every index
    for (int k = 0; k < 16; k++) begin
      cfg_lut = 16'(1) << k;
      for (int i = 0; i < 16; i++) begin
        din = 4'(i); #1;
        chk("R1 lut onehot", comb_out, (i == k));
        chk("R1 carry idle", carry_out, 1'b0);
        chk("R2 lut chain", lut_chain_out, (i == k));
        chk("R11 comb select", cell_out, (i == k));
      end
    end
    cfg_lut = 16'h6996;
    for (int i = 0; i < 16; i++) begin
      din = 4'(i); #1;
      chk("R1 lut parity", comb_out, ^(4'(i)));
    end

    // R3 R4 R2: arithmetic sweep
    cfg_arith = 1;
    for (int m = 0; m < 32; m++) begin
      logic a, b, c, s, f, bb, ci;
      logic [1:0] tot;
      a = m[0]; b = m[1]; c = m[2]; s = m[3]; f = m[4];
      din = {2'b00, b, a}; carry_in = c; add_sub = s; cfg_first = f; #1;
      bb = s ? ~b : b;
      ci = f ? s : c;
      tot = 2'(a) + 2'(bb) + 2'(ci);
      chk("R3 sum", comb_out, tot[0]);
      chk("R3 carry", carry_out, tot[1]);
      chk("R4 carry-in select", comb_out, a ^ bb ^ ci);
      chk("R2 chain arith", lut_chain_out, tot[0]);
    end
    cfg_arith = 0; add_sub = 0; carry_in = 0; cfg_first = 0;
    cfg_lut = 16'hAAAA;  // comb_out = din[0]

    // R9 local capture, R11 register select
    ena_bus = 2'b01; cfg_out_reg = 1; din = 4'b0001;
    tick();
    chk("R9 local data", reg_out, 1'b1);
    din = 4'b0000; #1;
    chk("R11 reg select", cell_out, 1'b1);
    chk("R9 chain out", reg_chain_out, 1'b1);

    // R7 enable low holds
    ena_bus = 2'b00; tick();
    chk("R7 hold data", reg_out, 1'b1);
    sclr = 1; tick();
    chk("R7 hold sclr", reg_out, 1'b1);
    sclr = 0; sload = 1; ld_data = 0; tick();
    chk("R7 hold sload", reg_out, 1'b1);

    // R8 priorities
    ena_bus = 2'b01; sclr = 1; sload = 1; ld_data = 1; din = 4'b0001; tick();
    chk("R8 sclr over sload", reg_out, 1'b0);
    sclr = 0; sload = 1; ld_data = 1; din = 4'b0000; tick();
    chk("R8 sload over data", reg_out, 1'b1);
    sload = 0; ld_data = 0; din = 4'b0000; tick();
    chk("R8 normal data", reg_out, 1'b0);

    // R9 register chain source
    cfg_chain_src = 1; reg_chain_in = 1; din = 4'b0000; tick();
    chk("R9 chain in high", reg_out, 1'b1);
    reg_chain_in = 0; din = 4'b0001; tick();
    chk("R9 chain in low", reg_out, 1'b0);
    cfg_chain_src = 0;

    // R10 clock select with linked enable
    cfg_clk_sel = 1; ena_bus = 2'b01; din = 4'b0001; tick();
    chk("R10 other enable ignored", reg_out, 1'b0);
    ena_bus = 2'b10; tick();
    chk("R10 linked enable", reg_out, 1'b1);
    din = 4'b0000; tick();
    chk("R10 linked enable clear", reg_out, 1'b0);
    cfg_clk_sel = 0; ena_bus = 2'b00;

    // R5 asynchronous controls
    #2; ld_data = 1; aload = 1; #1;
    chk("R5 preset", reg_out, 1'b1);
    ld_data = 0; #1;
    chk("R5 load follows", reg_out, 1'b0);
    ld_data = 1; #1; aclr = 1; #1;
    chk("R5 clear over load", reg_out, 1'b0);
    tick();
    chk("R5 clear held", reg_out, 1'b0);
    aclr = 0; #1;
    chk("R5 load after clear", reg_out, 1'b1);
    tick();
    aload = 0; #1;
    chk("R5 load retained", reg_out, 1'b1);

    // R6 reset not gated by enable
    ena_bus = 2'b00; rst = 1; tick();
    chk("R6 reset clears", reg_out, 1'b0);
    rst = 0; tick();

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule